// File: doc/BRIEF.md
# Li-ion Pack Protection Controller

This block guards a single lithium-ion cell. It compares a digitized cell-voltage word, a signed sense-resistor voltage word and two comparator bits against fixed thresholds. Each fault condition must hold for its own qualification delay before it counts. Once a fault qualifies, the block opens the charge FET, the discharge FET or both through active-low control outputs. Each fault then stays in force until its own release rule is met. Releases come from the cell voltage, from a discharge current, or from a comparison of the pack terminal against the supply.

Four sticky fault flags, two host-writable enable bits and two read-only copies of the FET outputs make up an 8-bit protection register. The register is read back on a port and written through a simple write strobe. A power-mode controller drives the `active` input. The block raises `sleep_req` after an undervoltage. When the controller returns the device to active mode, both enable bits are forced back on.

Top module: `li_pack_guard`

## Requirements
- R1: If `cell_v > OV_TH` is sampled on OV_DLY consecutive rising edges while active, then after the last of those edges `chg_n` is 1 and flag bit 7 (overvoltage) is 1. `dsg_n` is unaffected.
- R2: An active overvoltage is released, and `chg_n` returns low one edge later, when `cell_v < CE_TH` or `sense_v <= DSG_REL_TH`. The overvoltage flag stays set.
- R3: If `cell_v < UV_TH` is sampled on UV_DLY consecutive edges, then both outputs go to 1, flag bit 6 is set and `sleep_req` goes to 1.
- R4: If `sense_v > OC_TH` is sampled on OC_DLY consecutive edges, then both outputs go to 1 and flag bit 5 is set. This charge overcurrent is released only by an edge that samples `pls_above` = 0.
- R5: If `sense_v < -OC_TH` is sampled on OC_DLY consecutive edges, then `dsg_n` goes to 1 and flag bit 4 is set. The release comes only from an edge that samples `pls_above` = 1.
- R6: If `sc_trip` is sampled high on SC_DLY consecutive edges, then `dsg_n` goes to 1 and the same flag bit 4 is set. The release rule is that of R5.
- R7: Bit 1 (CE) = 0 forces `chg_n` to 1. Bit 0 (DE) = 0 forces `dsg_n` to 1. Both outputs are 1 from the edge after `active` is sampled low.
- R8: A host write clears each flag in bits 7..4 whose data bit is 0 and keeps those whose data bit is 1. A fault qualifying on the same edge as a clear leaves its flag set.
- R9: Bit 3 reads `chg_n` and bit 2 reads `dsg_n`. Writes to these two bits have no effect.
- R10: On the first edge that samples `active` = 1 after it was 0, CE and DE are set to 1 and the undervoltage state (`sleep_req`) is cleared. The flags are kept.
- R11: A qualification condition that drops for one edge restarts its delay count from zero.
- R12: After reset, `prot_reg` reads 8'h0F and both outputs are 1 (sleep).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active | input | 1 | Power mode from the mode controller, 1 = active |
| cell_v | input | CELL_W | Cell voltage, unsigned |
| sense_v | input | SENSE_W | Sense-resistor voltage, signed, positive = charging |
| sc_trip | input | 1 | Short-circuit comparator output |
| pls_above | input | 1 | Pack terminal above supply minus switch drop |
| wr_en | input | 1 | Protection register write strobe |
| wr_data | input | 8 | Protection register write data |
| chg_n | output | 1 | Charge FET control, 1 = FET off |
| dsg_n | output | 1 | Discharge FET control, 1 = FET off |
| sleep_req | output | 1 | Undervoltage sleep request |
| prot_reg | output | 8 | Protection register readback |

## Verification
Every fault result is due right after the edge that samples its condition for the delay-th consecutive time. Every release, enable write and wake result is due right after the single edge that samples its cause. The bench changes inputs on the falling edge and counts rising edges exactly. For each fault it first checks that the output is still unchanged one edge before the due edge, and then checks the new value on the falling edge after it. For the set-versus-clear case, a write is placed on the very edge where the short-circuit count completes.

// File: rtl/pack_guard_pkg.sv
package pack_guard_pkg;

    // Bit positions inside the protection register
    localparam int unsigned BIT_OV  = 7;
    localparam int unsigned BIT_UV  = 6;
    localparam int unsigned BIT_COC = 5;
    localparam int unsigned BIT_DOC = 4;
    localparam int unsigned BIT_CCM = 3;
    localparam int unsigned BIT_DCM = 2;
    localparam int unsigned BIT_CE  = 1;
    localparam int unsigned BIT_DE  = 0;

    // Qualification timer slots
    localparam int unsigned T_OV   = 0;
    localparam int unsigned T_UV   = 1;
    localparam int unsigned T_COC  = 2;
    localparam int unsigned T_DOC  = 3;
    localparam int unsigned T_SC   = 4;
    localparam int unsigned N_TMR  = 5;

    typedef struct packed {
        logic ov;
        logic uv;
        logic coc;
        logic doc;
    } fault_vec_t;

endpackage

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
    parameter int unsigned DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int unsigned CNT_W = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = cond && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!cond) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pg_prot_reg.sv
module pg_prot_reg
    import pack_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fault_vec_t set_i,
    input  logic       wake_i,
    input  logic       wr_en,
    input  fault_vec_t keep_i,
    input  logic       ce_wr_i,
    input  logic       de_wr_i,
    output fault_vec_t flag_o,
    output logic       ce_o,
    output logic       de_o
);
    typedef struct packed {
        fault_vec_t flag;
        logic       ce;
        logic       de;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.flag = r_q.flag & keep_i;
            r_d.ce   = ce_wr_i;
            r_d.de   = de_wr_i;
        end
        // a newly qualified fault wins over a clear
        r_d.flag = r_d.flag | set_i;
        if (wake_i) begin
            r_d.ce = 1'b1;
            r_d.de = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{flag: '0, ce: 1'b1, de: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign flag_o = r_q.flag;
    assign ce_o   = r_q.ce;
    assign de_o   = r_q.de;
endmodule

// File: rtl/li_pack_guard.sv
module li_pack_guard
    import pack_guard_pkg::*;
#(
    parameter int unsigned CELL_W  = 10,
    parameter int unsigned SENSE_W = 13,
    parameter logic [CELL_W-1:0] OV_TH = 10'd891,
    parameter logic [CELL_W-1:0] CE_TH = 10'd840,
    parameter logic [CELL_W-1:0] UV_TH = 10'd512,
    parameter logic signed [SENSE_W-1:0] OC_TH      = 13'sd1600,
    parameter logic signed [SENSE_W-1:0] DSG_REL_TH = -13'sd128,
    parameter int unsigned OV_DLY = 16,
    parameter int unsigned UV_DLY = 16,
    parameter int unsigned OC_DLY = 8,
    parameter int unsigned SC_DLY = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      active,
    input  logic [CELL_W-1:0]         cell_v,
    input  logic signed [SENSE_W-1:0] sense_v,
    input  logic                      sc_trip,
    input  logic                      pls_above,
    input  logic                      wr_en,
    input  logic [7:0]                wr_data,
    output logic                      chg_n,
    output logic                      dsg_n,
    output logic                      sleep_req,
    output logic [7:0]                prot_reg
);
    localparam logic signed [SENSE_W-1:0] OC_NEG = -OC_TH;
    localparam int unsigned DLY_TAB [N_TMR] = '{OV_DLY, UV_DLY, OC_DLY, OC_DLY, SC_DLY};

    typedef struct packed {
        fault_vec_t act;
        logic       awake;
    } st_t;

    st_t st_d, st_q;

    logic [N_TMR-1:0] cond;
    logic [N_TMR-1:0] hit;
    fault_vec_t       set_v;
    fault_vec_t       flag_v;
    fault_vec_t       keep_v;
    logic             ce_q, de_q;
    logic             wake;
    logic             chg_off, dsg_off;
    logic             unused_mirror_wr;

    assign unused_mirror_wr = ^wr_data[BIT_CCM:BIT_DCM];

    // Qualification conditions, sampled only while awake
    always_comb begin
        cond         = '0;
        cond[T_OV]   = st_q.awake && (cell_v > OV_TH);
        cond[T_UV]   = st_q.awake && (cell_v < UV_TH);
        cond[T_COC]  = st_q.awake && (sense_v > OC_TH);
        cond[T_DOC]  = st_q.awake && (sense_v < OC_NEG);
        cond[T_SC]   = st_q.awake && sc_trip;
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        pg_qual_timer #(.DLY(DLY_TAB[i])) tmr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (cond[i]),
            .hit   (hit[i])
        );
    end

    assign wake = active && !st_q.awake;

    always_comb begin
        set_v.ov  = hit[T_OV];
        set_v.uv  = hit[T_UV];
        set_v.coc = hit[T_COC];
        set_v.doc = hit[T_DOC] | hit[T_SC];
    end

    // Fault state: each fault has its own release rule
    always_comb begin
        st_d       = st_q;
        st_d.awake = active;

        // overvoltage: release has priority so a discharge reopens the path
        if (set_v.ov) begin
            st_d.act.ov = 1'b1;
        end
        if ((cell_v < CE_TH) || (sense_v <= DSG_REL_TH)) begin
            st_d.act.ov = 1'b0;
        end

        // undervoltage: held until the device is woken again
        if (wake) begin
            st_d.act.uv = 1'b0;
        end else if (set_v.uv) begin
            st_d.act.uv = 1'b1;
        end

        // charge overcurrent: pack terminal pulled below the threshold
        if (set_v.coc) begin
            st_d.act.coc = 1'b1;
        end else if (!pls_above) begin
            st_d.act.coc = 1'b0;
        end

        // discharge overcurrent or short: pack terminal back above
        if (set_v.doc) begin
            st_d.act.doc = 1'b1;
        end else if (pls_above) begin
            st_d.act.doc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        keep_v.ov  = wr_data[BIT_OV];
        keep_v.uv  = wr_data[BIT_UV];
        keep_v.coc = wr_data[BIT_COC];
        keep_v.doc = wr_data[BIT_DOC];
    end

    pg_prot_reg prot_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .wake_i  (wake),
        .wr_en   (wr_en),
        .keep_i  (keep_v),
        .ce_wr_i (wr_data[BIT_CE]),
        .de_wr_i (wr_data[BIT_DE]),
        .flag_o  (flag_v),
        .ce_o    (ce_q),
        .de_o    (de_q)
    );

    always_comb begin
        chg_off = st_q.act.ov | st_q.act.uv | st_q.act.coc | !ce_q | !st_q.awake;
        dsg_off = st_q.act.uv | st_q.act.coc | st_q.act.doc | !de_q | !st_q.awake;
    end

    assign chg_n     = chg_off;
    assign dsg_n     = dsg_off;
    assign sleep_req = st_q.act.uv;

    always_comb begin
        prot_reg          = '0;
        prot_reg[BIT_OV]  = flag_v.ov;
        prot_reg[BIT_UV]  = flag_v.uv;
        prot_reg[BIT_COC] = flag_v.coc;
        prot_reg[BIT_DOC] = flag_v.doc;
        prot_reg[BIT_CCM] = chg_off;
        prot_reg[BIT_DCM] = dsg_off;
        prot_reg[BIT_CE]  = ce_q;
        prot_reg[BIT_DE]  = de_q;
    end
endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic       wr_en,
    input logic       chg_n,
    input logic       dsg_n,
    input logic       sleep_req,
    input logic [7:0] prot_reg
);
    // R1
    ov_opens_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_reg[7]) |-> chg_n);

    // R3
    uv_opens_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (chg_n && dsg_n));

    // R7
    de_low_blocks_dsg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_reg[0] |-> dsg_n);

    // R7
    ce_low_blocks_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_reg[1] |-> chg_n);

    // R7
    sleep_blocks_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (chg_n && dsg_n));

    // R8
    ov_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_reg[7] && !wr_en) |=> prot_reg[7]);

    // R8
    doc_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_reg[4] && !wr_en) |=> prot_reg[4]);

    // R10
    wake_sets_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> (prot_reg[1] && prot_reg[0] && !sleep_req));
endmodule

bind li_pack_guard pg_guard_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .wr_en     (wr_en),
    .chg_n     (chg_n),
    .dsg_n     (dsg_n),
    .sleep_req (sleep_req),
    .prot_reg  (prot_reg)
);

// File: tb/li_pack_guard_tb_top.sv
module li_pack_guard_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              active = 1'b0;
    logic [9:0]        cell_v = 10'd800;
    logic signed [12:0] sense_v = '0;
    logic              sc_trip = 1'b0;
    logic              pls_above = 1'b1;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              chg_n, dsg_n, sleep_req;
    logic [7:0]        prot_reg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    li_pack_guard dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .cell_v    (cell_v),
        .sense_v   (sense_v),
        .sc_trip   (sc_trip),
        .pls_above (pls_above),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .chg_n     (chg_n),
        .dsg_n     (dsg_n),
        .sleep_req (sleep_req),
        .prot_reg  (prot_reg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset_wake;
        chk("R12 prot_reg after reset", prot_reg, 8'h0F);
        chk("R12 outputs off in sleep", {chg_n, dsg_n}, 2'b11);
        active = 1'b1;
        step(1);
        chk("R10 outputs on after wake", {chg_n, dsg_n}, 2'b00);
        chk("R9 mirrors track outputs", prot_reg, 8'h03);
    endtask

    task automatic t_overvoltage;
        cell_v = 10'd900;
        step(15);
        chk("R1 charge still on before delay", chg_n, 1'b0);
        step(1);
        chk("R1 charge off after delay", {chg_n, dsg_n}, 2'b10);
        chk("R1 OV flag set", prot_reg[7], 1'b1);
        chk("R9 CC mirror high", prot_reg[3], 1'b1);
        cell_v = 10'd870;
        step(3);
        chk("R2 held above release level", chg_n, 1'b1);
        sense_v = -13'sd128;
        step(1);
        chk("R2 released by discharge current", chg_n, 1'b0);
        chk("R2 OV flag kept", prot_reg[7], 1'b1);
        sense_v = '0;
        host_wr(8'h03);
        chk("R8 OV flag cleared by write", prot_reg[7], 1'b0);
        cell_v = 10'd900;
        step(16);
        chk("R1 second overvoltage", chg_n, 1'b1);
        cell_v = 10'd820;
        step(1);
        chk("R2 released by cell below CE level", chg_n, 1'b0);
        host_wr(8'h03);
    endtask

    task automatic t_restart;
        cell_v = 10'd900;
        step(15);
        cell_v = 10'd800;
        step(1);
        cell_v = 10'd900;
        step(15);
        chk("R11 count restarted after drop", {chg_n, prot_reg[7]}, 2'b00);
        cell_v = 10'd800;
        step(1);
        sc_trip = 1'b1;
        step(1);
        sc_trip = 1'b0;
        step(1);
        sc_trip = 1'b1;
        step(1);
        sc_trip = 1'b0;
        step(1);
        chk("R11 split short pulses ignored", {dsg_n, prot_reg[4]}, 2'b00);
    endtask

    task automatic t_charge_oc;
        sense_v = 13'sd1700;
        step(7);
        chk("R4 on before delay", {chg_n, dsg_n}, 2'b00);
        step(1);
        chk("R4 both off", {chg_n, dsg_n}, 2'b11);
        chk("R4 COC flag", prot_reg[5], 1'b1);
        sense_v = '0;
        step(3);
        chk("R4 held while pack terminal high", {chg_n, dsg_n}, 2'b11);
        pls_above = 1'b0;
        step(1);
        chk("R4 released by pack terminal low", {chg_n, dsg_n}, 2'b00);
        pls_above = 1'b1;
        host_wr(8'h03);
    endtask

    task automatic t_discharge_oc;
        pls_above = 1'b0;
        sense_v   = -13'sd1700;
        step(8);
        chk("R5 discharge off only", {chg_n, dsg_n}, 2'b01);
        chk("R5 DOC flag", prot_reg[4], 1'b1);
        sense_v = '0;
        step(3);
        chk("R5 held while pack terminal low", dsg_n, 1'b1);
        pls_above = 1'b1;
        step(1);
        chk("R5 released by pack terminal high", dsg_n, 1'b0);
        host_wr(8'h03);
    endtask

    task automatic t_short;
        pls_above = 1'b0;
        sc_trip   = 1'b1;
        step(1);
        chk("R6 on before short delay", dsg_n, 1'b0);
        wr_en   = 1'b1;
        wr_data = 8'h03;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        sc_trip = 1'b0;
        chk("R6 discharge off on short", dsg_n, 1'b1);
        chk("R8 set wins over same-edge clear", prot_reg[4], 1'b1);
        step(2);
        chk("R6 held while pack terminal low", dsg_n, 1'b1);
        pls_above = 1'b1;
        step(1);
        chk("R6 released by pack terminal high", dsg_n, 1'b0);
        host_wr(8'hFF);
        chk("R8 keep bit preserves flag", prot_reg[4], 1'b1);
        host_wr(8'h03);
        chk("R8 zero bit clears flag", prot_reg[4], 1'b0);
    endtask

    task automatic t_enables;
        host_wr(8'h02);
        chk("R7 DE low blocks discharge", {chg_n, dsg_n}, 2'b01);
        chk("R9 register readback with DE low", prot_reg, 8'h06);
        host_wr(8'h09);
        chk("R7 CE low blocks charge", {chg_n, dsg_n}, 2'b10);
        chk("R9 mirror bit write ignored", prot_reg, 8'h09);
        host_wr(8'h03);
        chk("R7 both enabled", {chg_n, dsg_n}, 2'b00);
    endtask

    task automatic t_undervoltage;
        cell_v = 10'd400;
        step(15);
        chk("R3 on before delay", {chg_n, dsg_n, sleep_req}, 3'b000);
        step(1);
        chk("R3 both off and sleep requested", {chg_n, dsg_n, sleep_req}, 3'b111);
        chk("R3 UV flag", prot_reg[6], 1'b1);
        active = 1'b0;
        cell_v = 10'd800;
        step(1);
        host_wr(8'h40);
        chk("R7 sleep keeps outputs off", {chg_n, dsg_n}, 2'b11);
        chk("R10 enables low before wake", prot_reg[1:0], 2'b00);
        active = 1'b1;
        step(1);
        chk("R10 wake restores enables, clears request", prot_reg, 8'h43);
        chk("R10 outputs on after wake", {chg_n, dsg_n, sleep_req}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_wake();
        t_overvoltage();
        t_restart();
        t_charge_oc();
        t_discharge_oc();
        t_short();
        t_enables();
        t_undervoltage();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule